// File: doc/BRIEF.md
# Dual-Channel Interrupt Pending and Vector Logic

This block holds the interrupt-pending state of a two-channel serial controller. Each channel (A and B) has three interrupt sources: receive character available, transmit buffer empty, and external/status change. Single-cycle event pulses from the channel logic set a pending flag when that source is enabled. Command codes written by software clear the flags again, either per source or by removing the flag that currently has the highest priority. All six flags are reported in one pending byte. An interrupt request line is raised while the master enable is on and any flag is pending.

The block also holds a shared interrupt vector byte that software writes. Channel A reads the stored value unchanged. Channel B reads the same byte with a 3-bit status field put in its place. The field names the highest-priority pending source and its channel. The field sits either in bits 3:1 or in bits 6:4, chosen by a placement input. Every output is registered.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, pend_byte is 0x00, irq is 0, vec_a is 0x00, and vec_b equals the stored value 0x00 with the no-pending field 3'b011 in the selected position (0x06 when stat_hi is 0).
- R2: pend_byte bits: 0 = B ext/status, 1 = B transmit, 2 = B receive, 3 = A ext/status, 4 = A transmit, 5 = A receive; bits 7:6 read 0. An enabled event pulse sets its bit one clock later. Index 1 of each event and enable vector is channel A and index 0 is channel B. Receive is enabled when the channel's two rx_mode bits are nonzero (rx_mode[3:2] is A, rx_mode[1:0] is B).
- R3: An event pulse from a disabled source leaves pend_byte unchanged.
- R4: With cmd_valid high, cmd_code 2 clears the ext/status flag, 4 (arm next receive) clears the receive flag, and 5 clears the transmit flag, all of the channel named by cmd_chan (1 = A, 0 = B). The other channel is not touched.
- R5: cmd_code 7 clears only the highest-priority pending flag of all six, with priority A receive > A transmit > A ext/status > B receive > B transmit > B ext/status.
- R6: cmd_code 0, 1, 3 and 6 leave the flags unchanged.
- R7: When an enabled event and a clear of the same flag come in the same cycle, the flag stays set.
- R8: irq is 1 exactly when mie was 1 at the last edge and the flags updated at that edge are not all zero.
- R9: vec_a shows the stored vector; a write with vec_wr appears one clock later.
- R10: vec_b's 3-bit status field is {channel, code} of the highest pending source: A receive 110, A transmit 100, A ext/status 101, B receive 010, B transmit 000, B ext/status 001.
- R11: With no flag pending, the vec_b field reads 011 (channel B special receive).
- R12: stat_hi 0 puts the field in vec_b bits 3:1 and stat_hi 1 puts it in bits 6:4. All other vec_b bits equal the stored vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rx | input | 2 | Receive character available pulses ([1] A, [0] B) |
| ev_tx | input | 2 | Transmit buffer empty pulses |
| ev_xs | input | 2 | External/status change pulses |
| en_xs | input | 2 | Ext/status interrupt enables |
| en_tx | input | 2 | Transmit interrupt enables |
| rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel ([3:2] A, [1:0] B) |
| mie | input | 1 | Master interrupt enable |
| stat_hi | input | 1 | Status field placement in vec_b (0: bits 3:1, 1: bits 6:4) |
| cmd_valid | input | 1 | Command strobe |
| cmd_chan | input | 1 | Channel of the command (1 = A) |
| cmd_code | input | 3 | Command code |
| vec_wr | input | 1 | Vector write strobe |
| vec_wdata | input | 8 | Vector write data |
| pend_byte | output | 8 | Packed pending flags |
| vec_a | output | 8 | Stored vector, unmodified |
| vec_b | output | 8 | Vector with status field inserted |
| irq | output | 1 | Interrupt request |

## Verification
Events, commands and vector writes take effect at the next rising edge. All four outputs are registered from the updated state, so every result is due exactly one edge after its stimulus. The bench drives inputs on the falling edge and updates its reference model at the rising edge that samples them. It compares the outputs at the following falling edge, where they have settled and the next stimulus has not yet been applied. Same-cycle set and clear, and a highest-priority clear, are each checked within that single edge.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NCH   = 2;
  localparam int NSRC  = 3;
  localparam int NPEND = NCH * NSRC;

  // source slot inside one channel's group of flags
  localparam int SRC_XS = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_RX = 2;

  // two-bit condition codes placed below the channel bit
  localparam logic [1:0] ST_TX   = 2'b00;
  localparam logic [1:0] ST_XS   = 2'b01;
  localparam logic [1:0] ST_RX   = 2'b10;
  localparam logic [1:0] ST_SPEC = 2'b11;

  typedef enum logic [2:0] {
    CMD_NOP0    = 3'd0,
    CMD_NOP1    = 3'd1,
    CMD_CLR_XS  = 3'd2,
    CMD_NOP3    = 3'd3,
    CMD_ARM_RX  = 3'd4,
    CMD_CLR_TX  = 3'd5,
    CMD_ERR_RST = 3'd6,
    CMD_CLR_TOP = 3'd7
  } cmd_e;
endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] nxt_o,
  output logic [NSRC-1:0] q_o
);
  // a set in the same cycle as a clear wins
  always_comb nxt_o = (q_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec
  import sio_irq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int FIELD_W = 3,
  parameter int LO_POS  = 1,
  parameter int HI_POS  = 4
) (
  input  logic [NPEND-1:0] pend_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             hi_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [FIELD_W-1:0] field;

  // higher flag index means higher priority; later iterations win
  always_comb begin
    field = {1'b0, ST_SPEC};
    for (int i = 0; i < NPEND; i++) begin
      if (pend_i[i]) begin
        field[FIELD_W-1] = (i >= NSRC);
        case (i % NSRC)
          SRC_RX:  field[FIELD_W-2:0] = ST_RX;
          SRC_TX:  field[FIELD_W-2:0] = ST_TX;
          default: field[FIELD_W-2:0] = ST_XS;
        endcase
      end
    end
  end

  always_comb begin
    vec_o = vec_i;
    if (hi_i) vec_o[HI_POS +: FIELD_W] = field;
    else      vec_o[LO_POS +: FIELD_W] = field;
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   ev_rx,
  input  logic [NCH-1:0]   ev_tx,
  input  logic [NCH-1:0]   ev_xs,
  input  logic [NCH-1:0]   en_xs,
  input  logic [NCH-1:0]   en_tx,
  input  logic [2*NCH-1:0] rx_mode,
  input  logic             mie,
  input  logic             stat_hi,
  input  logic             cmd_valid,
  input  logic             cmd_chan,
  input  logic [2:0]       cmd_code,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wdata,
  output logic [VEC_W-1:0] pend_byte,
  output logic [VEC_W-1:0] vec_a,
  output logic [VEC_W-1:0] vec_b,
  output logic             irq
);
  localparam int PAD_W = VEC_W - NPEND;

  logic [NPEND-1:0] pend_q, pend_nxt, set_v, clr_v, top_hot;
  logic [VEC_W-1:0] vec_q, vec_nxt, vec_b_nxt;
  logic [NPEND-1:0] pend_to_vec;
  logic [VEC_W-1:0] vec_to_vec;
  int               base;

  // per-channel flag groups
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign set_v[c*NSRC + SRC_XS] = ev_xs[c] & en_xs[c];
    assign set_v[c*NSRC + SRC_TX] = ev_tx[c] & en_tx[c];
    assign set_v[c*NSRC + SRC_RX] = ev_rx[c] & (|rx_mode[2*c +: 2]);

    sio_irq_chan #(.NSRC(NSRC)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[c*NSRC +: NSRC]),
      .clr_i (clr_v[c*NSRC +: NSRC]),
      .nxt_o (pend_nxt[c*NSRC +: NSRC]),
      .q_o   (pend_q[c*NSRC +: NSRC])
    );
  end

  // command decode
  always_comb begin
    clr_v   = '0;
    top_hot = '0;
    base    = cmd_chan ? NSRC : 0;
    for (int i = 0; i < NPEND; i++) begin
      if (pend_q[i]) begin
        top_hot    = '0;
        top_hot[i] = 1'b1;
      end
    end
    if (cmd_valid) begin
      case (cmd_e'(cmd_code))
        CMD_CLR_XS:  clr_v[base + SRC_XS] = 1'b1;
        CMD_ARM_RX:  clr_v[base + SRC_RX] = 1'b1;
        CMD_CLR_TX:  clr_v[base + SRC_TX] = 1'b1;
        CMD_CLR_TOP: clr_v = top_hot;
        default:     clr_v = '0;
      endcase
    end
  end

  // stored vector
  always_comb vec_nxt = vec_wr ? vec_wdata : vec_q;

  always_ff @(posedge clk) begin
    if (rst) vec_q <= '0;
    else     vec_q <= vec_nxt;
  end

  // during reset the merged vector is built from the cleared state
  assign pend_to_vec = rst ? '0 : pend_nxt;
  assign vec_to_vec  = rst ? '0 : vec_nxt;

  sio_irq_vec #(.VEC_W(VEC_W)) u_vec (
    .pend_i (pend_to_vec),
    .vec_i  (vec_to_vec),
    .hi_i   (stat_hi),
    .vec_o  (vec_b_nxt)
  );

  always_ff @(posedge clk) begin
    vec_b <= vec_b_nxt;
    if (rst) irq <= 1'b0;
    else     irq <= mie & (|pend_nxt);
  end

  assign pend_byte = {{PAD_W{1'b0}}, pend_q};
  assign vec_a     = vec_q;
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ev_rx,
  input logic [1:0] ev_tx,
  input logic [1:0] en_tx,
  input logic [3:0] rx_mode,
  input logic       mie,
  input logic       stat_hi,
  input logic       cmd_valid,
  input logic       cmd_chan,
  input logic [2:0] cmd_code,
  input logic       vec_wr,
  input logic [7:0] pend_byte,
  input logic [7:0] vec_a,
  input logic [7:0] vec_b,
  input logic       irq
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(!mie) |-> !irq); // R8

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend_byte != 8'h00)); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(ev_rx[1] && (rx_mode[3:2] != 2'b00)) |-> pend_byte[5]); // R7

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    $past(!en_tx[0] && !pend_byte[1]) |-> !pend_byte[1]); // R3

  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid && cmd_code == 3'd5 && cmd_chan && !ev_tx[1]) |-> !pend_byte[4]); // R4

  AST_VEC_A_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!vec_wr) |-> $stable(vec_a)); // R9

  AST_NONE_SPEC: assert property (@(posedge clk) disable iff (rst)
    ($past(!stat_hi) && pend_byte == 8'h00) |-> (vec_b[3:1] == 3'b011)); // R11
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk u_chk (.*);

// File: tb/sio_irq_ctrl_test.sv
module sio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] ev_rx, ev_tx, ev_xs, en_xs, en_tx;
  logic [3:0] rx_mode;
  logic       mie, stat_hi, cmd_valid, cmd_chan, vec_wr;
  logic [2:0] cmd_code;
  logic [7:0] vec_wdata;
  logic [7:0] pend_byte, vec_a, vec_b;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] m_pend;
  logic [7:0] m_vec, m_vecb;
  logic       m_irq;

  always #10 clk = ~clk;

  sio_irq_ctrl uut (
    .clk(clk), .rst(rst), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_xs(ev_xs),
    .en_xs(en_xs), .en_tx(en_tx), .rx_mode(rx_mode), .mie(mie),
    .stat_hi(stat_hi), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
    .cmd_code(cmd_code), .vec_wr(vec_wr), .vec_wdata(vec_wdata),
    .pend_byte(pend_byte), .vec_a(vec_a), .vec_b(vec_b), .irq(irq)
  );

  // highest pending flag index, -1 if none
  function automatic int top_idx(input logic [5:0] p);
    int r = -1;
    for (int i = 0; i < 6; i++) if (p[i]) r = i;
    return r;
  endfunction

  function automatic logic [5:0] mdl_pend(input logic [5:0] p);
    logic [5:0] s, c;
    int t;
    s = {ev_rx[1] & (rx_mode[3:2] != 0), ev_tx[1] & en_tx[1], ev_xs[1] & en_xs[1],
         ev_rx[0] & (rx_mode[1:0] != 0), ev_tx[0] & en_tx[0], ev_xs[0] & en_xs[0]};
    c = 6'b0;
    if (cmd_valid) begin
      case (cmd_code)
        3'd2: c[cmd_chan ? 3 : 0] = 1'b1;
        3'd4: c[cmd_chan ? 5 : 2] = 1'b1;
        3'd5: c[cmd_chan ? 4 : 1] = 1'b1;
        3'd7: begin t = top_idx(p); if (t >= 0) c[t] = 1'b1; end
        default: c = 6'b0;
      endcase
    end
    return (p & ~c) | s;
  endfunction

  function automatic logic [7:0] mdl_vecb(input logic [5:0] p, input logic [7:0] v, input logic hi);
    logic [2:0] f;
    logic [7:0] r;
    case (top_idx(p))
      5: f = 3'b110;
      4: f = 3'b100;
      3: f = 3'b101;
      2: f = 3'b010;
      1: f = 3'b000;
      0: f = 3'b001;
      default: f = 3'b011;
    endcase
    r = v;
    if (hi) r[6:4] = f; else r[3:1] = f;
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic quiet();
    ev_rx = 0; ev_tx = 0; ev_xs = 0; cmd_valid = 0; cmd_code = 0; cmd_chan = 0; vec_wr = 0;
  endtask

  // one edge: model update at posedge, compare at the following negedge, then clear pulses
  task automatic tick(input string tag);
    @(posedge clk);
    m_pend = mdl_pend(m_pend);
    if (vec_wr) m_vec = vec_wdata;
    m_irq  = mie & (m_pend != 0);
    m_vecb = mdl_vecb(m_pend, m_vec, stat_hi);
    @(negedge clk);
    check(tag, "pend_byte (R2)", pend_byte, {2'b00, m_pend});
    check(tag, "irq (R8)", {7'b0, irq}, {7'b0, m_irq});
    check(tag, "vec_a (R9)", vec_a, m_vec);
    check(tag, "vec_b (R10)", vec_b, m_vecb);
    quiet();
  endtask

  task automatic cmd(input logic ch, input logic [2:0] code);
    cmd_valid = 1'b1; cmd_chan = ch; cmd_code = code;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    quiet();
    rst = 1'b1; en_xs = 0; en_tx = 0; rx_mode = 0; mie = 0; stat_hi = 0; vec_wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pend = 0; m_vec = 0; m_irq = 0; m_vecb = mdl_vecb(0, 0, 1'b0);
    check("R1", "pend_byte", pend_byte, 8'h00);
    check("R1", "irq", {7'b0, irq}, 8'h00);
    check("R1", "vec_a", vec_a, 8'h00);
    check("R1", "vec_b", vec_b, 8'h06);

    en_xs = 2'b11; en_tx = 2'b11; rx_mode = 4'b0110; mie = 1'b1;
    ev_tx[0] = 1'b1; tick("R2");
    check("R8", "irq raised", {7'b0, irq}, 8'h01);
    ev_rx[1] = 1'b1; tick("R10");
    check("R10", "A receive field", vec_b, 8'h0C);
    stat_hi = 1'b1; vec_wr = 1'b1; vec_wdata = 8'h81; tick("R12");
    check("R12", "high placement", vec_b, 8'hE1);
    cmd(1'b0, 3'd7); tick("R5");
    check("R5", "top cleared", pend_byte, 8'h02);
    cmd(1'b0, 3'd5); ev_tx[0] = 1'b1; tick("R7");
    check("R7", "set wins", pend_byte, 8'h02);
    cmd(1'b0, 3'd5); tick("R4");
    check("R11", "no pending field", vec_b, 8'hB1);
    check("R8", "irq dropped", {7'b0, irq}, 8'h00);
    en_xs[1] = 1'b0; ev_xs[1] = 1'b1; tick("R3");
    rx_mode[3:2] = 2'b00; ev_rx[1] = 1'b1; tick("R3");
    check("R3", "disabled ignored", pend_byte, 8'h00);
    ev_xs[0] = 1'b1; tick("R2");
    foreach (seed_codes[k]) begin
      cmd(1'b0, seed_codes[k]); tick("R6");
      check("R6", "no-op code", pend_byte, 8'h01);
    end
    cmd(1'b1, 3'd2); tick("R4");
    check("R4", "other channel kept", pend_byte, 8'h01);
    cmd(1'b0, 3'd2); tick("R4");
    check("R4", "ext/status cleared", pend_byte, 8'h00);
    mie = 1'b0; ev_tx[1] = 1'b1; tick("R8");
    check("R8", "masked", {7'b0, irq}, 8'h00);
    ev_rx[0] = 1'b1; tick("R2");
    cmd(1'b0, 3'd4); tick("R4");
    check("R4", "receive cleared", pend_byte, 8'h10);

    for (int n = 0; n < 3000; n++) begin
      ev_rx = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      ev_tx = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      ev_xs = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) begin
        en_xs = 2'($urandom_range(0, 3)); en_tx = 2'($urandom_range(0, 3));
        rx_mode = 4'($urandom_range(0, 15)); mie = 1'($urandom_range(0, 1));
        stat_hi = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 1) == 1) cmd(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      vec_wr = ($urandom_range(0, 7) == 0);
      vec_wdata = 8'($urandom_range(0, 255));
      tick("random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [2:0] seed_codes [4] = '{3'd0, 3'd1, 3'd3, 3'd6};
endmodule